// File: doc/BRIEF.md
# Image Sensor Frame Timing Generator

This block paces the readout of an image sensor array. It produces a frame sync, a line sync, a data-valid strobe, the current row and column, and an even/odd line flag. Software-visible settings are sampled as plain inputs: the window origin (row and column), the window size, an integration time, and an integration mode select. The integration time is counted in whole lines in line mode and in single clocks in pixel mode. Raising the enable input starts the first frame. Clearing it stops the block at once.

Each frame has four parts. A setup line comes first, with the frame sync high. One line follows for each row of the effective window, and these lines alternate between even and odd. A transition comes last. If the integration time is longer than the readout of the window, the transition is stretched by an idle gap, so the next frame sync waits until the exposure is complete. The gap is computed in lines for line mode and in clocks for pixel mode.

Each line lasts `ARRAY_W` clocks, which is the sensor array width. The settings are copied into shadow registers in two cases only: when the block starts from idle, and on the last clock of each transition. A frame therefore always runs with one consistent set of values.

Top module: `sfg_frame_timer`

## Requirements
- R1: After reset, and on every clock edge that samples `enable_i` low, the block goes idle by the next edge. While idle, `vsync_o`, `hsync_o`, `dvalid_o` and `odd_line_o` are 0, and `row_o` and `col_o` are 0.
- R2: The first edge that samples `enable_i` high while idle starts a frame with a setup segment of `ARRAY_W` clocks. In this segment `vsync_o` is 1, `col_o` counts 0 to `ARRAY_W-1`, and `hsync_o`, `dvalid_o`, `odd_line_o` and `row_o` are 0.
- R3: After setup come EH lines of `ARRAY_W` clocks each, where EH is the effective height. In line k (k from 0), `row_o` is `row_start_i`+k, `col_o` counts 0 to `ARRAY_W-1`, and `vsync_o` is 0.
- R4: `hsync_o` is 1 during the first `HS_LEN` clocks of each line, and 0 at all other times. It is never high together with `vsync_o`.
- R5: `odd_line_o` equals bit 0 of the line index k, so the first line is even. It is 0 outside the lines.
- R6: `dvalid_o` is 1 only during a line, and only while `col_start_i` <= `col_o` < `col_start_i`+`win_width_i`.
- R7: EH equals `win_height_i` when `ARRAY_H` > `row_start_i`+`win_height_i`+1. Otherwise EH equals `ARRAY_H`-`row_start_i`-1, or 0 if that value is not positive.
- R8: After the last line (or directly after setup when EH is 0) comes a transition of 1+G clocks, where G is the idle gap. During the transition all outputs are 0. The next setup follows it directly.
- R9: In line mode (`pixel_mode_i`=0), G = (integration time − EH) × `ARRAY_W` when the integration time is greater than EH, and G = 0 otherwise.
- R10: In pixel mode (`pixel_mode_i`=1), G = integration time − EH × `ARRAY_W` when the integration time is greater than EH × `ARRAY_W`, and G = 0 otherwise.
- R11: The settings are sampled only when the block starts and on the last transition clock. A change during a frame has no effect on that frame, including its gap, and takes effect in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Run enable |
| row_start_i | input | ROW_W | First window row |
| win_height_i | input | ROW_W | Window height in rows |
| col_start_i | input | COL_W | First valid column |
| win_width_i | input | COL_W | Window width in columns |
| integ_time_i | input | INT_W | Integration time (lines or clocks) |
| pixel_mode_i | input | 1 | 0 selects line mode, 1 selects pixel mode |
| vsync_o | output | 1 | Frame sync, high during setup |
| hsync_o | output | 1 | Line sync |
| dvalid_o | output | 1 | Pixel data valid strobe |
| row_o | output | ROW_W | Current row address |
| col_o | output | COL_W | Current column count |
| odd_line_o | output | 1 | Odd line flag |

## Verification
All outputs are decoded without registers from the sequencer state. Frame cycle t is therefore visible after the (t+1)-th edge that samples `enable_i` high, and disabling takes effect one edge after `enable_i` is sampled low. The bench drives inputs and samples outputs on falling edges. It steps a frame-relative cycle index alongside the design and computes every output arithmetically for that index. The idle gap is checked by requiring the next frame sync in exactly cycle (1+EH)×`ARRAY_W`+1+G after the frame starts. The effective height is checked by counting line starts.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_LINE  = 2'd2,
    ST_TRANS = 2'd3
  } sfg_state_e;
endpackage

// File: rtl/sfg_shadow.sv
module sfg_shadow #(
  parameter int ROW_W = 10,
  parameter int COL_W = 11,
  parameter int INT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_start_i,
  input  logic [ROW_W-1:0] win_height_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic [COL_W-1:0] win_width_i,
  input  logic [INT_W-1:0] integ_time_i,
  input  logic             pixel_mode_i,
  output logic [ROW_W-1:0] row_start_o,
  output logic [ROW_W-1:0] win_height_o,
  output logic [COL_W-1:0] col_start_o,
  output logic [COL_W-1:0] win_width_o,
  output logic [INT_W-1:0] integ_time_o,
  output logic             pixel_mode_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_start_o  <= '0;
      win_height_o <= '0;
      col_start_o  <= '0;
      win_width_o  <= '0;
      integ_time_o <= '0;
      pixel_mode_o <= 1'b0;
    end else if (load_i) begin
      row_start_o  <= row_start_i;
      win_height_o <= win_height_i;
      col_start_o  <= col_start_i;
      win_width_o  <= win_width_i;
      integ_time_o <= integ_time_i;
      pixel_mode_o <= pixel_mode_i;
    end
  end
endmodule

// File: rtl/sfg_geom.sv
module sfg_geom #(
  parameter int ARRAY_W = 1024,
  parameter int ARRAY_H = 314,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 11,
  parameter int INT_W   = 20,
  parameter int GAP_W   = 31
) (
  input  logic [ROW_W-1:0] row_start_i,
  input  logic [ROW_W-1:0] win_height_i,
  input  logic [INT_W-1:0] integ_time_i,
  input  logic             pixel_mode_i,
  output logic [ROW_W-1:0] eff_height_o,
  output logic [GAP_W-1:0] gap_o
);
  localparam int WW = INT_W + ROW_W + COL_W + 1;

  logic [WW-1:0] rs_w, h_w, top_w, eff_w, scaled_w, integ_w, diff_w;

  always_comb begin
    rs_w    = WW'(row_start_i);
    h_w     = WW'(win_height_i);
    integ_w = WW'(integ_time_i);
    top_w   = rs_w + h_w + WW'(1);
    // clip window to the array
    if (WW'(ARRAY_H) > top_w)             eff_w = h_w;
    else if (WW'(ARRAY_H) > rs_w + WW'(1)) eff_w = WW'(ARRAY_H) - rs_w - WW'(1);
    else                                  eff_w = '0;
    scaled_w = pixel_mode_i ? eff_w * WW'(ARRAY_W) : eff_w;
    diff_w   = (integ_w > scaled_w) ? integ_w - scaled_w : '0;
    gap_o    = pixel_mode_i ? GAP_W'(diff_w) : GAP_W'(diff_w * WW'(ARRAY_W));
    eff_height_o = eff_w[ROW_W-1:0];
  end
endmodule

// File: rtl/sfg_seq.sv
module sfg_seq
  import sfg_pkg::*;
#(
  parameter int ARRAY_W = 1024,
  parameter int ROW_W   = 10,
  parameter int COL_W   = 11,
  parameter int GAP_W   = 31
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [ROW_W-1:0] eff_height_i,
  input  logic [GAP_W-1:0] gap_i,
  output logic             load_o,
  output sfg_state_e       state_o,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] line_o
);
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(ARRAY_W - 1);

  sfg_state_e       state_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] line_q;
  logic [GAP_W-1:0] gap_q;

  assign load_o = enable_i &&
                  ((state_q == ST_IDLE) || (state_q == ST_TRANS && gap_q == '0));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      line_q  <= '0;
      gap_q   <= '0;
    end else if (!enable_i) begin
      state_q <= ST_IDLE;
      col_q   <= '0;
      line_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_q <= ST_SETUP;
          col_q   <= '0;
        end
        ST_SETUP: begin
          if (col_q == COL_LAST) begin
            col_q  <= '0;
            line_q <= '0;
            if (eff_height_i == '0) begin
              state_q <= ST_TRANS;
              gap_q   <= gap_i;
            end else begin
              state_q <= ST_LINE;
            end
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        ST_LINE: begin
          if (col_q == COL_LAST) begin
            col_q <= '0;
            if (line_q == eff_height_i - ROW_W'(1)) begin
              state_q <= ST_TRANS;
              gap_q   <= gap_i;
            end else begin
              line_q <= line_q + ROW_W'(1);
            end
          end else begin
            col_q <= col_q + COL_W'(1);
          end
        end
        ST_TRANS: begin
          if (gap_q == '0) begin
            state_q <= ST_SETUP;
            col_q   <= '0;
          end else begin
            gap_q <= gap_q - GAP_W'(1);
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign col_o   = col_q;
  assign line_o  = line_q;
endmodule

// File: rtl/sfg_decode.sv
module sfg_decode
  import sfg_pkg::*;
#(
  parameter int HS_LEN = 16,
  parameter int ROW_W  = 10,
  parameter int COL_W  = 11
) (
  input  sfg_state_e       state_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [ROW_W-1:0] line_i,
  input  logic [ROW_W-1:0] row_start_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic [COL_W-1:0] win_width_i,
  output logic             vsync_o,
  output logic             hsync_o,
  output logic             dvalid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             odd_line_o
);
  logic             in_line;
  logic [COL_W:0]   col_end;

  always_comb begin
    in_line    = (state_i == ST_LINE);
    col_end    = {1'b0, col_start_i} + {1'b0, win_width_i};
    vsync_o    = (state_i == ST_SETUP);
    hsync_o    = in_line && (col_i < COL_W'(HS_LEN));
    dvalid_o   = in_line && (col_i >= col_start_i) && ({1'b0, col_i} < col_end);
    row_o      = in_line ? row_start_i + line_i : '0;
    odd_line_o = in_line && line_i[0];
    col_o      = (state_i == ST_SETUP || in_line) ? col_i : '0;
  end
endmodule

// File: rtl/sfg_frame_timer.sv
module sfg_frame_timer
  import sfg_pkg::*;
#(
  parameter  int ARRAY_W = 1024,
  parameter  int ARRAY_H = 314,
  parameter  int HS_LEN  = 16,
  parameter  int INT_W   = 20,
  localparam int COL_W   = $clog2(ARRAY_W) + 1,
  localparam int ROW_W   = $clog2(ARRAY_H) + 1,
  localparam int GAP_W   = INT_W + COL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic [ROW_W-1:0] row_start_i,
  input  logic [ROW_W-1:0] win_height_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic [COL_W-1:0] win_width_i,
  input  logic [INT_W-1:0] integ_time_i,
  input  logic             pixel_mode_i,
  output logic             vsync_o,
  output logic             hsync_o,
  output logic             dvalid_o,
  output logic [ROW_W-1:0] row_o,
  output logic [COL_W-1:0] col_o,
  output logic             odd_line_o
);
  logic             load;
  logic [ROW_W-1:0] sh_row_start, sh_height, eff_height, line;
  logic [COL_W-1:0] sh_col_start, sh_width, col_cnt;
  logic [INT_W-1:0] sh_integ;
  logic             sh_pix_mode;
  logic [GAP_W-1:0] gap;
  sfg_state_e       state;

  sfg_shadow #(.ROW_W(ROW_W), .COL_W(COL_W), .INT_W(INT_W)) i_shadow (
    .clk_i, .rst_ni, .load_i(load),
    .row_start_i, .win_height_i, .col_start_i, .win_width_i,
    .integ_time_i, .pixel_mode_i,
    .row_start_o(sh_row_start), .win_height_o(sh_height),
    .col_start_o(sh_col_start), .win_width_o(sh_width),
    .integ_time_o(sh_integ), .pixel_mode_o(sh_pix_mode)
  );

  sfg_geom #(
    .ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .ROW_W(ROW_W),
    .COL_W(COL_W), .INT_W(INT_W), .GAP_W(GAP_W)
  ) i_geom (
    .row_start_i(sh_row_start), .win_height_i(sh_height),
    .integ_time_i(sh_integ), .pixel_mode_i(sh_pix_mode),
    .eff_height_o(eff_height), .gap_o(gap)
  );

  sfg_seq #(.ARRAY_W(ARRAY_W), .ROW_W(ROW_W), .COL_W(COL_W), .GAP_W(GAP_W)) i_seq (
    .clk_i, .rst_ni, .enable_i,
    .eff_height_i(eff_height), .gap_i(gap),
    .load_o(load), .state_o(state), .col_o(col_cnt), .line_o(line)
  );

  sfg_decode #(.HS_LEN(HS_LEN), .ROW_W(ROW_W), .COL_W(COL_W)) i_decode (
    .state_i(state), .col_i(col_cnt), .line_i(line),
    .row_start_i(sh_row_start), .col_start_i(sh_col_start), .win_width_i(sh_width),
    .vsync_o, .hsync_o, .dvalid_o, .row_o, .col_o, .odd_line_o
  );
endmodule

// File: rtl/sfg_frame_timer_chk.sv
module sfg_frame_timer_chk #(
  parameter  int ARRAY_W = 1024,
  parameter  int ARRAY_H = 314,
  parameter  int HS_LEN  = 16,
  localparam int COL_W   = $clog2(ARRAY_W) + 1,
  localparam int ROW_W   = $clog2(ARRAY_H) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             vsync_o,
  input logic             hsync_o,
  input logic             dvalid_o,
  input logic [ROW_W-1:0] row_o,
  input logic [COL_W-1:0] col_o,
  input logic             odd_line_o
);
  // R1
  idle_on_disable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!vsync_o && !hsync_o && !dvalid_o && !odd_line_o));

  // R2
  start_vsync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_i) |=> (vsync_o && col_o == '0));

  // R2
  setup_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vsync_o && enable_i && col_o != COL_W'(ARRAY_W - 1)) |=>
      (vsync_o && col_o == $past(col_o) + COL_W'(1)));

  // R3
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dvalid_o && $past(dvalid_o) && col_o != '0) |-> (row_o == $past(row_o)));

  // R4
  sync_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vsync_o && hsync_o));

  // R4
  hsync_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hsync_o && enable_i && col_o < COL_W'(HS_LEN - 1)) |=> hsync_o);

  // R5
  odd_in_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_line_o |-> !vsync_o);

  // R6
  dv_in_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dvalid_o |-> !vsync_o);
endmodule

bind sfg_frame_timer sfg_frame_timer_chk #(
  .ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .HS_LEN(HS_LEN)
) i_chk (.*);

// File: tb/test_sfg_frame_timer.sv
module test_sfg_frame_timer;
  localparam int ARRAY_W = 32;
  localparam int ARRAY_H = 12;
  localparam int HS_LEN  = 4;
  localparam int INT_W   = 12;
  localparam int COL_W   = $clog2(ARRAY_W) + 1;
  localparam int ROW_W   = $clog2(ARRAY_H) + 1;
  localparam int L       = ARRAY_W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic enable = 1'b0;
  logic [ROW_W-1:0] row_start = '0, win_height = '0;
  logic [COL_W-1:0] col_start = '0, win_width = '0;
  logic [INT_W-1:0] integ = '0;
  logic pix_mode = 1'b0;
  logic vsync, hsync, dvalid, odd_line;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // mid-frame change request
  bit pend_chg = 0;
  int chg_cfg[6];

  always #5 clk = ~clk;

  sfg_frame_timer #(.ARRAY_W(ARRAY_W), .ARRAY_H(ARRAY_H), .HS_LEN(HS_LEN), .INT_W(INT_W))
  i_sfg_frame_timer (
    .clk_i(clk), .rst_ni, .enable_i(enable),
    .row_start_i(row_start), .win_height_i(win_height),
    .col_start_i(col_start), .win_width_i(win_width),
    .integ_time_i(integ), .pixel_mode_i(pix_mode),
    .vsync_o(vsync), .hsync_o(hsync), .dvalid_o(dvalid),
    .row_o(row), .col_o(col), .odd_line_o(odd_line)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_of(input int rs, input int h);
    if (ARRAY_H > rs + h + 1) return h;
    if (ARRAY_H > rs + 1) return ARRAY_H - rs - 1;
    return 0;
  endfunction

  function automatic int gap_of(input int rs, input int h, input int it, input int pm);
    int e;
    e = eff_of(rs, h);
    if (pm == 0) return (it > e) ? (it - e) * ARRAY_W : 0;
    return (it > e * ARRAY_W) ? it - e * ARRAY_W : 0;
  endfunction

  task automatic apply_cfg(input int c[6]);
    row_start  = ROW_W'(c[0]);
    win_height = ROW_W'(c[1]);
    col_start  = COL_W'(c[2]);
    win_width  = COL_W'(c[3]);
    integ      = INT_W'(c[4]);
    pix_mode   = (c[5] != 0);
  endtask

  task automatic check_idle(input string req);
    chk(req, "vsync", int'(vsync), 0);
    chk(req, "hsync", int'(hsync), 0);
    chk(req, "dvalid", int'(dvalid), 0);
    chk(req, "odd", int'(odd_line), 0);
    chk(req, "row", int'(row), 0);
    chk(req, "col", int'(col), 0);
  endtask

  // Check one cycle t of a frame run with config c
  task automatic check_cycle(input int t, input int c[6]);
    int e, u, r, cc;
    e = eff_of(c[0], c[1]);
    if (t < L) begin
      chk("R2", "vsync", int'(vsync), 1);
      chk("R2", "col", int'(col), t);
      chk("R2", "hsync", int'(hsync), 0);
      chk("R2", "dvalid", int'(dvalid), 0);
      chk("R2", "odd", int'(odd_line), 0);
      chk("R2", "row", int'(row), 0);
    end else if (t < L + e * L) begin
      u  = t - L;
      r  = u / L;
      cc = u % L;
      chk("R3", "vsync", int'(vsync), 0);
      chk("R3", "row", int'(row), c[0] + r);
      chk("R3", "col", int'(col), cc);
      chk("R4", "hsync", int'(hsync), (cc < HS_LEN) ? 1 : 0);
      chk("R5", "odd", int'(odd_line), r % 2);
      chk("R6", "dvalid", int'(dvalid), (cc >= c[2] && cc < c[2] + c[3]) ? 1 : 0);
    end else begin
      check_idle("R8");
    end
  endtask

  // Entry: at a falling edge showing frame cycle 0. Exit: at cycle 0 of the next frame.
  task automatic run_frame(input int c[6], output int lines);
    int p;
    p = L + eff_of(c[0], c[1]) * L + 1 + gap_of(c[0], c[1], c[4], c[5]);
    lines = 0;
    for (int t = 0; t < p; t++) begin
      check_cycle(t, c);
      if (hsync && col == '0) lines++;
      if (pend_chg && t == L + 40) begin
        apply_cfg(chg_cfg);
        pend_chg = 0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int cfgs[7][6];
    int lines;
    int x[6];
    int y[6];
    cfgs[0] = '{2, 5, 3, 10, 3, 0};    // no gap
    cfgs[1] = '{2, 5, 3, 10, 5, 0};    // integration equals height: no gap
    cfgs[2] = '{1, 4, 0, 32, 8, 0};    // line-mode gap 128, full-width valid
    cfgs[3] = '{0, 3, 5, 7, 146, 1};   // pixel-mode gap 50
    cfgs[4] = '{0, 3, 5, 7, 96, 1};    // pixel-mode equality: no gap
    cfgs[5] = '{6, 9, 28, 10, 2, 0};   // height clipped to 5, columns clipped
    cfgs[6] = '{11, 3, 0, 4, 0, 0};    // effective height 0

    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    check_idle("R1");

    foreach (cfgs[i]) begin
      apply_cfg(cfgs[i]);
      enable = 1'b1;
      @(negedge clk);
      for (int f = 0; f < 2; f++) begin
        run_frame(cfgs[i], lines);
        chk("R7", "line count", lines, eff_of(cfgs[i][0], cfgs[i][1]));
        chk((cfgs[i][5] != 0) ? "R10" : "R9", "vsync after gap", int'(vsync), 1);
      end
      enable = 1'b0;
      @(negedge clk);
      check_idle("R1");
    end

    // R11: settings changed mid-frame apply only from the next frame
    x = '{1, 3, 2, 6, 7, 0};    // gap (7-3)*32 = 128
    y = '{3, 6, 0, 9, 40, 1};   // gap 40 - 6*32 -> 0
    apply_cfg(x);
    chg_cfg = y;
    pend_chg = 1;
    enable = 1'b1;
    @(negedge clk);
    run_frame(x, lines);
    chk("R11", "old frame lines", lines, 3);
    chk("R11", "vsync with old gap", int'(vsync), 1);
    run_frame(y, lines);
    chk("R11", "new frame lines", lines, 6);
    enable = 1'b0;
    @(negedge clk);
    check_idle("R11");

    // R1: disable in the middle of a line
    apply_cfg(cfgs[0]);
    enable = 1'b1;
    @(negedge clk);
    repeat (L + L + 2) @(negedge clk);
    chk("R1", "hsync before disable", int'(hsync), 1);
    enable = 1'b0;
    @(negedge clk);
    check_idle("R1");
    @(negedge clk);
    check_idle("R1");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule